// File: doc/BRIEF.md
# Low-Power Interrupt Frame Timebase

This block runs from the 32.768 kHz slow clock. It divides that clock into a repeating interrupt-frame strobe. A 2-bit period field, written through a write-only configuration port, picks the frame length. With the default parameters the three usable settings give 8, 512 and 2048 slow-clock cycles, which is 0.244 ms, 15.625 ms and 62.5 ms. The fourth code is reserved.

The block has two event channels: timer overflow and external interrupt. When the system is in a low-power mode (watch or subactive), each channel latches its events and raises its request only in the cycle that follows a frame strobe. When the system is in active mode, or while it is moving to active mode, a channel passes its events straight through. Any event that is still held at that point is released at once.

Each channel is a two-state machine. In `CH_IDLE` nothing is pending. `CH_HOLD` means an event is latched. The transition `CH_IDLE -> CH_HOLD` happens on an event that arrives in frame-gated operation outside a strobe cycle. The transition `CH_HOLD -> CH_IDLE` happens on a strobe or on pass-through operation, and the request is issued at that moment. Whenever an event or a held event meets a strobe or pass-through, the request output is driven high for the next cycle. The gating decode has two states: `GATE_PASS` applies when the system is not in low-power mode or is moving to active mode. `GATE_FRAME` applies otherwise.

Top module: `ift_timebase`

## Requirements
- R1: During and right after reset, the strobe and both requests are low and the period field is 00, so the first strobe follows the shortest period.
- R2: With field 00, the strobe is high for one cycle every PER0 cycles. After reset or a restart, it first appears PER0 cycles later.
- R3: Field 01 gives a one-cycle strobe every PER1 cycles, and field 10 gives one every PER2 cycles.
- R4: Writing the reserved code 11 keeps the current period and does not disturb the strobe phase.
- R5: Writing a valid code that differs from the current one restarts the prescaler, so the next strobe comes exactly the new period after the write edge. Rewriting the current code does not restart it.
- R6: In frame-gated operation (low-power mode high, transition flag low), an event held in cycle j of a frame produces a one-cycle request in the cycle after the frame's strobe cycle, and never earlier.
- R7: Several events on one channel within a single frame give a single request. The held state is cleared when that request is issued, so the following frame stays quiet.
- R8: With the low-power mode input low, an event produces a request in the next cycle. Dropping the low-power mode input also releases a held event in the next cycle.
- R9: With the transition-to-active input high, events bypass strobe alignment and give a request in the next cycle. A held event is released in the cycle after the flag rises.
- R10: The timer and external channels are independent: an event on one never raises the other's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_mode | input | 1 | High while in watch or subactive mode |
| to_active | input | 1 | High during the transition to active mode |
| cfg_we | input | 1 | Write strobe for the period field |
| cfg_wdata | input | 2 | Period code: 00 short, 01 middle, 10 long, 11 reserved |
| tmr_evt | input | 1 | Raw timer overflow event |
| ext_evt | input | 1 | Raw external interrupt event |
| frame_stb | output | 1 | One-cycle interrupt-frame strobe |
| tmr_irq | output | 1 | Timer interrupt request |
| ext_irq | output | 1 | External interrupt request |

## Verification
The assertions assume the following about the inputs:
- All three periods are at least two cycles, so a strobe can never be high in two consecutive cycles.
- Every input is synchronous to the slow clock.
- The code 11 is never stored, because the register refuses it.

The stimulus stays within these assumptions. It uses small periods of 8, 12 and 20 cycles, changes every input only on the falling edge, and writes the reserved code only to check that it is ignored. Events are one-cycle pulses placed at every phase of every frame length, so the arithmetic release delay of period minus phase is checked at each offset.

// File: rtl/ift_pkg.sv
package ift_pkg;

    typedef enum logic [1:0] {
        FSEL_SHORT = 2'b00,
        FSEL_MID   = 2'b01,
        FSEL_LONG  = 2'b10,
        FSEL_RSVD  = 2'b11
    } fsel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_HOLD = 1'b1
    } ch_state_e;

    typedef enum logic {
        GATE_PASS  = 1'b0,
        GATE_FRAME = 1'b1
    } gate_e;

endpackage

// File: rtl/ift_cfg_reg.sv
module ift_cfg_reg
    import ift_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output fsel_e      sel,
    output logic       restart
);

    fsel_e sel_q;
    fsel_e wr_code;

    assign wr_code = fsel_e'(wdata);
    assign restart = we && (wr_code != FSEL_RSVD) && (wr_code != sel_q);
    assign sel     = sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= FSEL_SHORT;
        end else if (restart) begin
            sel_q <= wr_code;
        end
    end

endmodule

// File: rtl/ift_prescaler.sv
module ift_prescaler
    import ift_pkg::*;
#(
    parameter int PER0 = 8,
    parameter int PER1 = 512,
    parameter int PER2 = 2048
) (
    input  logic  clk,
    input  logic  rst_n,
    input  fsel_e sel,
    input  logic  restart,
    output logic  stb
);

    localparam int PMAX01 = (PER0 > PER1) ? PER0 : PER1;
    localparam int PMAX   = (PMAX01 > PER2) ? PMAX01 : PER2;
    localparam int CW     = (PMAX > 2) ? $clog2(PMAX) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (sel)
            FSEL_SHORT: limit = CW'(PER0 - 1);
            FSEL_MID:   limit = CW'(PER1 - 1);
            FSEL_LONG:  limit = CW'(PER2 - 1);
            FSEL_RSVD:  limit = CW'(PER0 - 1);
        endcase
    end

    assign stb = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || stb) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ift_event_chan.sv
module ift_event_chan
    import ift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic stb,
    input  gate_e gate,
    output logic irq,
    output logic hold
);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      release_now;
    logic      irq_d;

    assign release_now = (gate == GATE_PASS) || stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (evt && !release_now) state_d = CH_HOLD;
            CH_HOLD: if (release_now)         state_d = CH_IDLE;
        endcase
    end

    assign irq_d = (evt || (state_q == CH_HOLD)) && release_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= irq_d;
        end
    end

    assign hold = (state_q == CH_HOLD);

endmodule

// File: rtl/ift_timebase.sv
module ift_timebase
    import ift_pkg::*;
#(
    parameter int PER0 = 8,
    parameter int PER1 = 512,
    parameter int PER2 = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_mode,
    input  logic       to_active,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    input  logic       tmr_evt,
    input  logic       ext_evt,
    output logic       frame_stb,
    output logic       tmr_irq,
    output logic       ext_irq
);

    localparam int NCH = 2;

    fsel_e          sel;
    logic           restart;
    gate_e          gate;
    logic [NCH-1:0] evt_vec;
    logic [NCH-1:0] irq_vec;
    logic [NCH-1:0] ch_hold;

    assign gate    = (!lp_mode || to_active) ? GATE_PASS : GATE_FRAME;
    assign evt_vec = {ext_evt, tmr_evt};

    ift_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .sel     (sel),
        .restart (restart)
    );

    ift_prescaler #(
        .PER0 (PER0),
        .PER1 (PER1),
        .PER2 (PER2)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .restart (restart),
        .stb     (frame_stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ift_event_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_vec[c]),
            .stb   (frame_stb),
            .gate  (gate),
            .irq   (irq_vec[c]),
            .hold  (ch_hold[c])
        );
    end

    assign tmr_irq = irq_vec[0];
    assign ext_irq = irq_vec[1];

endmodule

// File: rtl/ift_timebase_chk.sv
module ift_timebase_chk
    import ift_pkg::*;
#(
    parameter int PER0 = 8,
    parameter int PER1 = 512,
    parameter int PER2 = 2048
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lp_mode,
    input logic       to_active,
    input logic       cfg_we,
    input logic [1:0] cfg_wdata,
    input logic       tmr_evt,
    input logic       ext_evt,
    input logic       frame_stb,
    input logic       tmr_irq,
    input logic       ext_irq,
    input fsel_e      sel,
    input logic       restart,
    input logic [1:0] ch_hold
);

    int unsigned gap;
    int unsigned lim_chk;

    always_comb begin
        unique case (sel)
            FSEL_SHORT: lim_chk = PER0 - 1;
            FSEL_MID:   lim_chk = PER1 - 1;
            FSEL_LONG:  lim_chk = PER2 - 1;
            FSEL_RSVD:  lim_chk = PER0 - 1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= 0;
        end else if (restart || frame_stb) begin
            gap <= 0;
        end else begin
            gap <= gap + 1;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb); // R2

    AST_STB_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (gap == lim_chk)); // R3

    AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata == 2'b11) |=> (sel == $past(sel))); // R4

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !frame_stb); // R5

    AST_TMR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> $past(frame_stb || !lp_mode || to_active)); // R6

    AST_EXT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> $past(frame_stb || !lp_mode || to_active)); // R6

    AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> !ch_hold[0]); // R7

    AST_PASS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_mode && tmr_evt) |=> tmr_irq); // R8

    AST_WAKE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (to_active && ch_hold[1]) |=> ext_irq); // R9

endmodule

bind ift_timebase ift_timebase_chk #(
    .PER0 (PER0),
    .PER1 (PER1),
    .PER2 (PER2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_mode   (lp_mode),
    .to_active (to_active),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .tmr_evt   (tmr_evt),
    .ext_evt   (ext_evt),
    .frame_stb (frame_stb),
    .tmr_irq   (tmr_irq),
    .ext_irq   (ext_irq),
    .sel       (sel),
    .restart   (restart),
    .ch_hold   (ch_hold)
);

// File: tb/test_ift_timebase.sv
module test_ift_timebase;

    localparam int P0 = 8;
    localparam int P1 = 12;
    localparam int P2 = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_mode = 1'b0;
    logic       to_active = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       tmr_evt = 1'b0;
    logic       ext_evt = 1'b0;
    logic       frame_stb;
    logic       tmr_irq;
    logic       ext_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int c0 = 0;
    int cur = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ift_timebase #(.PER0(P0), .PER1(P1), .PER2(P2)) i_ift_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .lp_mode   (lp_mode),
        .to_active (to_active),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tmr_evt   (tmr_evt),
        .ext_evt   (ext_evt),
        .frame_stb (frame_stb),
        .tmr_irq   (tmr_irq),
        .ext_irq   (ext_irq)
    );

    function automatic int per_of(int s);
        return (s == 1) ? P1 : (s == 2) ? P2 : P0;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic watch_stb(int n, string req);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, int'(frame_stb),
                  (((cyc - c0) % per_of(cur)) == per_of(cur) - 1) ? 1 : 0);
        end
    endtask

    task automatic write_sel(int s);
        cfg_we = 1'b1;
        cfg_wdata = 2'(s);
        if (s != 3 && s != cur) begin
            c0 = cyc + 1;
            cur = s;
        end
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic wait_stb();
        for (int i = 0; i < 100; i++) begin
            tick();
            if (frame_stb) break;
        end
    endtask

    task automatic set_evt(int ch, logic v);
        if (ch == 0) tmr_evt = v; else ext_evt = v;
    endtask

    task automatic phase_test(int ch, int j);
        int first = 0;
        int cnt = 0;
        int other = 0;
        int p = per_of(cur);
        wait_stb();
        repeat (j + 1) tick();
        set_evt(ch, 1'b1);
        for (int n = 1; n <= p + 1; n++) begin
            tick();
            set_evt(ch, 1'b0);
            if ((ch == 0 ? tmr_irq : ext_irq) == 1'b1) begin
                cnt++;
                if (first == 0) first = n;
            end
            if ((ch == 0 ? ext_irq : tmr_irq) == 1'b1) other++;
        end
        check($sformatf("R6 first request ch%0d sel%0d j%0d", ch, cur, j), first, p - j);
        check($sformatf("R6 request count ch%0d sel%0d j%0d", ch, cur, j), cnt, 1);
        check($sformatf("R10 other channel ch%0d j%0d", ch, j), other, 0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check("R1 strobe in reset", int'(frame_stb), 0);
        check("R1 tmr_irq in reset", int'(tmr_irq), 0);
        check("R1 ext_irq in reset", int'(ext_irq), 0);
        rst_n = 1'b1;
        c0 = cyc;
        cur = 0;
        check("R1 strobe after reset", int'(frame_stb), 0);
        watch_stb(3 * P0, "R2 default period");

        for (int s = 1; s <= 2; s++) begin
            write_sel(s);
            watch_stb(3 * per_of(s), "R3 period sweep");
        end
        write_sel(0);
        watch_stb(2 * P0, "R2 short period again");

        write_sel(2);
        watch_stb(5, "R4 before reserved");
        write_sel(3);
        watch_stb(2 * P2, "R4 reserved keeps period");

        write_sel(2);
        watch_stb(2 * P2, "R5 same code no restart");
        for (int k = 0; k < P1; k++) begin
            write_sel((k % 2 == 0) ? 1 : 0);
            repeat (k % 5) begin
                tick();
                check("R5 restart mid frame", int'(frame_stb),
                      (((cyc - c0) % per_of(cur)) == per_of(cur) - 1) ? 1 : 0);
            end
        end
        watch_stb(2 * P1, "R5 after restarts");

        lp_mode = 1'b1;
        to_active = 1'b0;
        for (int s = 0; s <= 2; s++) begin
            write_sel(s);
            for (int ch = 0; ch < 2; ch++) begin
                for (int j = 0; j < per_of(s); j++) begin
                    phase_test(ch, j);
                end
            end
        end

        write_sel(0);
        begin
            int cnt = 0;
            wait_stb();
            repeat (2) tick();
            tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
            tick();
            tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
            for (int n = 0; n < P0; n++) begin
                tick();
                if (tmr_irq) cnt++;
            end
            check("R7 merged request count", cnt, 1);
            cnt = 0;
            for (int n = 0; n < 2 * P0; n++) begin
                tick();
                if (tmr_irq) cnt++;
            end
            check("R7 pending cleared", cnt, 0);
        end

        lp_mode = 1'b0;
        for (int j = 0; j < 10; j++) begin
            int ch = j % 2;
            set_evt(ch, 1'b1);
            tick();
            set_evt(ch, 1'b0);
            check($sformatf("R8 pass-through ch%0d j%0d", ch, j),
                  int'(ch == 0 ? tmr_irq : ext_irq), 1);
            check($sformatf("R10 pass other ch%0d j%0d", ch, j),
                  int'(ch == 0 ? ext_irq : tmr_irq), 0);
            repeat (j % 3) tick();
            tick();
            check($sformatf("R8 pass pulse ends j%0d", j),
                  int'(ch == 0 ? tmr_irq : ext_irq), 0);
        end

        lp_mode = 1'b1;
        to_active = 1'b1;
        for (int j = 0; j < 6; j++) begin
            ext_evt = 1'b1;
            tick();
            ext_evt = 1'b0;
            check($sformatf("R9 wake bypass j%0d", j), int'(ext_irq), 1);
            repeat (j % 4 + 1) tick();
        end
        to_active = 1'b0;

        for (int ch = 0; ch < 2; ch++) begin
            wait_stb();
            tick();
            set_evt(ch, 1'b1);
            tick();
            set_evt(ch, 1'b0);
            check($sformatf("R9 held before flush ch%0d", ch),
                  int'(ch == 0 ? tmr_irq : ext_irq), 0);
            to_active = 1'b1;
            tick();
            check($sformatf("R9 flush on transition ch%0d", ch),
                  int'(ch == 0 ? tmr_irq : ext_irq), 1);
            to_active = 1'b0;
            tick();
        end

        wait_stb();
        tick();
        tmr_evt = 1'b1;
        tick();
        tmr_evt = 1'b0;
        check("R8 held before mode drop", int'(tmr_irq), 0);
        lp_mode = 1'b0;
        tick();
        check("R8 flush on active mode", int'(tmr_irq), 1);
        tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule